// File: doc/BRIEF.md
# Complex Reference Signal Mixer

This stage sits between a carrier wipe-off stage and the integrate-and-dump accumulators of a correlator channel that tracks signals with multi-level complex subcarriers. Each sample period it takes a complex carrier-wiped sample and a complex local reference. It multiplies the sample by the conjugate of the reference and registers the real and imaginary products as two small signed values. An accumulator that follows can add these values directly.

The sample rails use a compact level code that an adder cannot use as it stands. The reference rails are built inside the block from a two-level-magnitude subcarrier, and the spreading-code bit only inverts their sign. Four small product tables, one for each cross term, feed two adders.

Top module: `cmix_correlator`

## Requirements
- R1: Each sample rail code is 3 bits. Bit 2 is the sign (1 = negative). Bits 1:0 select the magnitude: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 6.
- R2: Each subcarrier rail code is 2 bits. Bit 1 is the sign (1 = negative) and bit 0 is the magnitude (0 gives 1, 1 gives 2). When `code_bit` is 1, both reference rails are inverted in sign.
- R3: The real result equals sI·rI + sQ·rQ, written as 6-bit two's complement.
- R4: The imaginary result equals sQ·rI − sI·rQ, written as 6-bit two's complement.
- R5: A sample presented with `in_valid` high appears on `corr_re`/`corr_im` after the next rising clock edge. `out_valid` is high for that one cycle.
- R6: In a cycle where `in_valid` is low, `out_valid` goes low at the next edge and both results keep their previous values, whatever the other inputs do.
- R7: While `rst` is high at a clock edge, `out_valid` becomes 0 and both results become 0.
- R8: Every result stays within −24 to +24. Both extremes can be reached on each output without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| samp_i | input | 3 | In-phase carrier-wiped sample, level code |
| samp_q | input | 3 | Quadrature carrier-wiped sample, level code |
| sub_i | input | 2 | In-phase subcarrier level code |
| sub_q | input | 2 | Quadrature subcarrier level code |
| code_bit | input | 1 | Spreading-code chip; 1 inverts the reference |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| corr_re | output | 6 | Real sample correlation, signed |
| corr_im | output | 6 | Imaginary sample correlation, signed |

## Verification
The assertions assume that the input codes are fully driven (never X) in every cycle. They also assume that reset is held for at least one edge before the first sample. The range checks rely on the magnitude codes topping out at 6 and 2, so every 3-bit and 2-bit pattern is legal. The stimulus walks every one of the 2048 input combinations with no illegal code to avoid, and it holds reset from time zero. It also changes the sample and reference inputs during strobe-low cycles, so the hold behaviour is exercised with inputs that are actually moving.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

    localparam int SAMP_W    = 3;
    localparam int REF_W     = 2;
    localparam int PP_W      = 5;
    localparam int SUM_W     = PP_W + 1;
    localparam int IDX_W     = SAMP_W + REF_W;
    localparam int LUT_DEPTH = 1 << IDX_W;
    localparam int NUM_PP    = 4;
    localparam int PP_MAX    = 12;
    localparam int CORR_MAX  = 2 * PP_MAX;

    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } samp_code_t;

    typedef struct packed {
        logic neg;
        logic big;
    } ref_code_t;

    typedef logic signed [PP_W-1:0]  pp_t;
    typedef logic signed [SUM_W-1:0] corr_t;

    function automatic int samp_level(input samp_code_t c);
        int m;
        case (c.mag)
            2'b00:   m = 1;
            2'b01:   m = 2;
            2'b10:   m = 3;
            default: m = 6;
        endcase
        return c.neg ? -m : m;
    endfunction

    function automatic int ref_level(input ref_code_t c);
        int m;
        m = c.big ? 2 : 1;
        return c.neg ? -m : m;
    endfunction

    // Table entry: index = {sample code, reference code}; optional negation
    function automatic pp_t pp_entry(input logic [IDX_W-1:0] idx, input logic negate);
        int p;
        p = samp_level(samp_code_t'(idx[IDX_W-1:REF_W])) * ref_level(ref_code_t'(idx[REF_W-1:0]));
        if (negate) p = -p;
        return pp_t'(p);
    endfunction

endpackage

// File: rtl/cmix_ref_former.sv
module cmix_ref_former
    import cmix_pkg::*;
(
    input  ref_code_t sub_i,
    input  ref_code_t sub_q,
    input  logic      code_bit,
    output ref_code_t ref_i,
    output ref_code_t ref_q
);
    // The chip only flips the sign; the magnitude passes through untouched.
    always_comb begin
        ref_i.neg = sub_i.neg ^ code_bit;
        ref_i.big = sub_i.big;
        ref_q.neg = sub_q.neg ^ code_bit;
        ref_q.big = sub_q.big;
    end
endmodule

// File: rtl/cmix_pp_lut.sv
module cmix_pp_lut
    import cmix_pkg::*;
#(
    parameter bit NEGATE = 1'b0
) (
    input  samp_code_t samp,
    input  ref_code_t  refc,
    output pp_t        prod
);
    pp_t table_q [LUT_DEPTH];

    for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_entry
        assign table_q[k] = pp_entry(IDX_W'(k), NEGATE);
    end

    assign prod = table_q[{samp, refc}];
endmodule

// File: rtl/cmix_pair_add.sv
module cmix_pair_add
    import cmix_pkg::*;
(
    input  pp_t   a,
    input  pp_t   b,
    output corr_t sum
);
    assign sum = corr_t'(a) + corr_t'(b);

    always_comb begin
        AST_SUM_RANGE: assert (sum >= -CORR_MAX && sum <= CORR_MAX); // R8
    end
endmodule

// File: rtl/cmix_correlator.sv
module cmix_correlator
    import cmix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        samp_i,
    input  logic [2:0]        samp_q,
    input  logic [1:0]        sub_i,
    input  logic [1:0]        sub_q,
    input  logic              code_bit,
    output logic              out_valid,
    output logic signed [5:0] corr_re,
    output logic signed [5:0] corr_im
);
    samp_code_t s_i, s_q;
    ref_code_t  r_i, r_q;
    samp_code_t lut_s [NUM_PP];
    ref_code_t  lut_r [NUM_PP];
    pp_t        pp    [NUM_PP];
    corr_t      re_d, im_d;

    assign s_i = samp_code_t'(samp_i);
    assign s_q = samp_code_t'(samp_q);

    cmix_ref_former u_ref (
        .sub_i   (ref_code_t'(sub_i)),
        .sub_q   (ref_code_t'(sub_q)),
        .code_bit(code_bit),
        .ref_i   (r_i),
        .ref_q   (r_q)
    );

    // Table 0: sI*rI, 1: sQ*rQ, 2: -(sI*rQ), 3: sQ*rI
    assign lut_s[0] = s_i;  assign lut_r[0] = r_i;
    assign lut_s[1] = s_q;  assign lut_r[1] = r_q;
    assign lut_s[2] = s_i;  assign lut_r[2] = r_q;
    assign lut_s[3] = s_q;  assign lut_r[3] = r_i;

    for (genvar g = 0; g < NUM_PP; g++) begin : g_pp
        cmix_pp_lut #(.NEGATE(g == 2)) u_lut (
            .samp(lut_s[g]),
            .refc(lut_r[g]),
            .prod(pp[g])
        );
    end

    cmix_pair_add u_add_re (.a(pp[0]), .b(pp[1]), .sum(re_d));
    cmix_pair_add u_add_im (.a(pp[3]), .b(pp[2]), .sum(im_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            corr_re   <= '0;
            corr_im   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                corr_re <= re_d;
                corr_im <= im_d;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(corr_re) && $stable(corr_im))); // R6

    AST_RE_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (corr_re >= -CORR_MAX && corr_re <= CORR_MAX)); // R8

    AST_IM_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (corr_im >= -CORR_MAX && corr_im <= CORR_MAX)); // R8
endmodule

// File: tb/cmix_correlator_test.sv
module cmix_correlator_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [2:0]        samp_i = '0, samp_q = '0;
    logic [1:0]        sub_i = '0, sub_q = '0;
    logic              code_bit = 1'b0;
    logic              out_valid;
    logic signed [5:0] corr_re, corr_im;

    int errors = 0, checks = 0;
    int exp_re = 0, exp_im = 0;
    bit exp_v = 1'b0, last_in_v = 1'b0, last_rst = 1'b1, seen_edge = 1'b0, done = 1'b0;
    int max_re = -99, min_re = 99, max_im = -99, min_im = 99;

    cmix_correlator uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .samp_i(samp_i), .samp_q(samp_q), .sub_i(sub_i), .sub_q(sub_q),
        .code_bit(code_bit), .out_valid(out_valid),
        .corr_re(corr_re), .corr_im(corr_im)
    );

    // R1 level decode
    function automatic int s_lvl(input logic [2:0] c);
        int m;
        m = (c[1:0] == 2'd3) ? 6 : int'(c[1:0]) + 1;
        return c[2] ? -m : m;
    endfunction

    // R2 level decode, chip inverts
    function automatic int r_lvl(input logic [1:0] c, input logic chip);
        int m;
        m = c[0] ? 2 : 1;
        if (c[1] ^ chip) m = -m;
        return m;
    endfunction

    // Behavioural reference model, advanced on every edge
    always @(posedge clk) begin
        seen_edge = 1'b1;
        last_in_v = in_valid;
        last_rst  = rst;
        if (rst) begin
            exp_v = 1'b0; exp_re = 0; exp_im = 0;
        end else if (in_valid) begin
            exp_v  = 1'b1;
            exp_re = s_lvl(samp_i) * r_lvl(sub_i, code_bit) + s_lvl(samp_q) * r_lvl(sub_q, code_bit);
            exp_im = s_lvl(samp_q) * r_lvl(sub_i, code_bit) - s_lvl(samp_i) * r_lvl(sub_q, code_bit);
        end else begin
            exp_v = 1'b0;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL %s out_valid got %0b exp %0b", last_rst ? "R7" : (last_in_v ? "R5" : "R6"), out_valid, exp_v);
            end
            checks++;
            if (int'(corr_re) != exp_re) begin
                errors++;
                $display("FAIL %s corr_re got %0d exp %0d", last_rst ? "R7" : (last_in_v ? "R3" : "R6"), corr_re, exp_re);
            end
            checks++;
            if (int'(corr_im) != exp_im) begin
                errors++;
                $display("FAIL %s corr_im got %0d exp %0d", last_rst ? "R7" : (last_in_v ? "R4" : "R6"), corr_im, exp_im);
            end
            if (out_valid) begin
                if (int'(corr_re) > max_re) max_re = int'(corr_re);
                if (int'(corr_re) < min_re) min_re = int'(corr_re);
                if (int'(corr_im) > max_im) max_im = int'(corr_im);
                if (int'(corr_im) < min_im) min_im = int'(corr_im);
            end
        end
    end

    task automatic expect_pair(input string tag, input int re, input int im);
        checks++;
        if (int'(corr_re) != re || int'(corr_im) != im || out_valid !== 1'b1) begin
            errors++;
            $display("FAIL %s re/im/v got %0d/%0d/%0b exp %0d/%0d/1", tag, corr_re, corr_im, out_valid, re, im);
        end
    endtask

    task automatic apply(input logic [2:0] si, input logic [2:0] sq,
                         input logic [1:0] ri, input logic [1:0] rq, input logic cb);
        @(negedge clk);
        samp_i = si; samp_q = sq; sub_i = ri; sub_q = rq; code_bit = cb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_cnt(input string tag, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, want);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state observed while reset is still applied
        checks++;
        if (out_valid !== 1'b0 || corr_re !== 6'sd0 || corr_im !== 6'sd0) begin
            errors++;
            $display("FAIL R7 reset v/re/im got %0b/%0d/%0d exp 0/0/0", out_valid, corr_re, corr_im);
        end
        rst = 1'b0;

        apply(3'b010, 3'b000, 2'b00, 2'b00, 1'b0); expect_pair("R1 mag3",   4, -2);
        apply(3'b111, 3'b000, 2'b00, 2'b00, 1'b0); expect_pair("R1 neg6",  -5, 7);
        apply(3'b010, 3'b000, 2'b00, 2'b00, 1'b1); expect_pair("R2 chip",  -4, 2);
        apply(3'b010, 3'b000, 2'b01, 2'b00, 1'b0); expect_pair("R2 mag2",   7, -1);
        apply(3'b001, 3'b010, 2'b10, 2'b01, 1'b0); expect_pair("R3 R4 mix", 4, -7);
        apply(3'b011, 3'b011, 2'b01, 2'b01, 1'b0); expect_pair("R8 re max", 24, 0);
        apply(3'b111, 3'b111, 2'b01, 2'b01, 1'b0); expect_pair("R8 re min", -24, 0);
        apply(3'b111, 3'b011, 2'b01, 2'b01, 1'b0); expect_pair("R8 im max", 0, 24);
        apply(3'b011, 3'b111, 2'b01, 2'b01, 1'b0); expect_pair("R8 im min", 0, -24);

        // Exhaustive walk; strobe dropped periodically while inputs keep moving (R6)
        for (int n = 0; n < 2048; n++) begin
            @(negedge clk);
            samp_i   = n[2:0];
            samp_q   = n[5:3];
            sub_i    = n[7:6];
            sub_q    = n[9:8];
            code_bit = n[10];
            in_valid = (n % 7) != 3;
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            samp_i = 3'(n * 5); samp_q = 3'(n * 3); sub_i = 2'(n); sub_q = 2'(n + 1); code_bit = n[0];
        end
        @(negedge clk);
        expect_cnt("R8 re peak",   max_re, 24);
        expect_cnt("R8 re trough", min_re, -24);
        expect_cnt("R8 im peak",   max_im, 24);
        expect_cnt("R8 im trough", min_im, -24);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule